// File: doc/BRIEF.md
# Serial Display Link Start-Up Sequencer

This block is the transmit-side controller that brings a three-wire, current-mode serial display link (one clock lane, two data lanes) out of its off state and keeps it running. It watches an active-low power-down pin, a per-pixel-clock edge strobe and a PLL-lock indication. After the power-down pin is released and the pixel clock is present, it waits a fixed number of pixel-clock edges for the PLL to settle. It then walks the lanes through a three-stage level pattern that the receiver uses to set its current thresholds. Once that is done, it lets the clock lane toggle, lets the data lanes stream and marks the link up.

Lane levels leave the block as abstract two-bit codes, and an external current driver turns them into line current. The block runs on a free-running clock at the serial-clock rate, so the serial clock is six times the pixel clock. A built-in monitor declares the pixel clock lost when no edge strobe has arrived within a parameterised timeout. Losing the pixel clock, or asserting power-down, drops every lane to off at once and lowers the power-down output. When the pixel clock returns, the whole sequence runs again from the start.

Top module: `link_startup_seq`

## Requirements
- R1: While in reset, or while `pd_n` is low, every lane code is 0 (off), `pd_out_n` is low and `link_up` is low. Lane codes are 0 off, 1 logic low (high current), 2 logic high (low current) and 3 active.
- R2: No lane leaves code 0 until at least 4096 pixel edges have been seen since power-up and `pll_lock` is high. The count does not exceed 4098 when the lock is already present.
- R3: The first calibration stage holds the clock lane at code 1 for exactly 180 cycles, with both data lanes at code 0.
- R4: The second stage follows directly and holds the clock lane at code 2 for exactly 180 cycles, with both data lanes at code 0.
- R5: The third stage follows directly and holds the clock lane and both data lanes at code 1 for exactly 180 cycles.
- R6: After the third stage, the clock lane and the data lanes carry code 3 and `link_up` is high. This holds for as long as `pd_n` stays high and pixel edges keep arriving.
- R7: If no pixel edge arrives for more than LOSS_TIMEOUT+1 cycles, all lanes are at code 0 and `pd_out_n` is low.
- R8: When pixel edges resume after a loss, the full lock wait (R2) and the calibration stages (R3 to R5) run again before the link comes back up.
- R9: `pd_out_n` goes high one cycle after `pd_n` is high with the pixel clock present. `link_up` is never high while `pd_out_n` is low.
- R10: Driving `pd_n` low at any point, including mid-calibration, forces all lanes to code 0 and `pd_out_n` low by the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at the serial-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down request, low = powered down |
| pix_edge | input | 1 | One-cycle strobe per pixel-clock rising edge, already in the clk domain |
| pll_lock | input | 1 | PLL lock indication |
| clk_lane | output | 2 | Level code for the clock lane |
| data_lane | output | 2*DATA_LANES | Level codes for the data lanes, lane 0 in the low bits |
| pd_out_n | output | 1 | Power-down output for the receiver, high while the sequencer is powered |
| link_up | output | 1 | High while the link is streaming |

## Verification
The assertions assume that `pix_edge` is a clean single-cycle strobe already synchronised to `clk`. They also assume that `pd_n` and `pll_lock` change only between edges. The stage-length and ordering properties rely on lane codes changing only through the sequencer's own state. The bench therefore drives every input a fixed delay after the rising edge and produces pixel edges as one-cycle pulses every six cycles. It stops them outright to model clock loss and never glitches them.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int LOCK_PIX_DEF = 4096;
    localparam int CAL_LEN_DEF  = 180;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2,
        LANE_ACT  = 2'd3
    } lane_code_t;

    typedef enum logic [5:0] {
        ST_OFF     = 6'b000001,
        ST_LOCK    = 6'b000010,
        ST_CAL_LO  = 6'b000100,
        ST_CAL_HI  = 6'b001000,
        ST_CAL_ALL = 6'b010000,
        ST_ACTIVE  = 6'b100000
    } lss_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lss_clk_monitor.sv
module lss_clk_monitor #(
    parameter int LOSS_TIMEOUT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_edge,
    output logic pix_lost
);
    localparam int GW = $clog2(LOSS_TIMEOUT + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(LOSS_TIMEOUT - 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            pix_lost <= 1'b1;
        end else if (pix_edge) begin
            gap      <= '0;
            pix_lost <= 1'b0;
        end else if (gap == GAP_LAST) begin
            pix_lost <= 1'b1;
        end else if (!pix_lost) begin
            gap <= gap + 1'b1;
        end
    end
endmodule

// File: rtl/lss_seq_fsm.sv
module lss_seq_fsm
    import lss_pkg::*;
#(
    parameter int LOCK_PIX = LOCK_PIX_DEF,
    parameter int CAL_LEN  = CAL_LEN_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_n,
    input  logic       pix_edge,
    input  logic       pix_lost,
    input  logic       pll_lock,
    output lss_state_t state
);
    localparam int CNT_W = $clog2(max_int(LOCK_PIX, CAL_LEN));
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_PIX - 1);
    localparam logic [CNT_W-1:0] CAL_LOAD  = CNT_W'(CAL_LEN - 1);

    lss_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;
    logic             in_cal;

    assign cnt_zero = (cnt == '0);
    assign in_cal   = (state == ST_CAL_LO) || (state == ST_CAL_HI) ||
                      (state == ST_CAL_ALL);

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = CAL_LOAD;
        if (!pd_n || pix_lost) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt      = ST_LOCK;
                    load     = 1'b1;
                    load_val = LOCK_LOAD;
                end
                ST_LOCK: begin
                    if (pix_edge && cnt_zero && pll_lock) begin
                        nxt  = ST_CAL_LO;
                        load = 1'b1;
                    end
                end
                ST_CAL_LO: begin
                    if (cnt_zero) begin
                        nxt  = ST_CAL_HI;
                        load = 1'b1;
                    end
                end
                ST_CAL_HI: begin
                    if (cnt_zero) begin
                        nxt  = ST_CAL_ALL;
                        load = 1'b1;
                    end
                end
                ST_CAL_ALL: begin
                    if (cnt_zero) nxt = ST_ACTIVE;
                end
                ST_ACTIVE: nxt = ST_ACTIVE;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (load) begin
                cnt <= load_val;
            end else if (state == ST_LOCK) begin
                if (pix_edge && !cnt_zero) cnt <= cnt - 1'b1;
            end else if (in_cal && !cnt_zero) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/lss_lane_encoder.sv
module lss_lane_encoder
    import lss_pkg::*;
#(
    parameter int DATA_LANES = 2
) (
    input  lss_state_t              state,
    output logic [1:0]              clk_code,
    output logic [2*DATA_LANES-1:0] data_code
);
    always_comb begin
        unique case (state)
            ST_CAL_LO, ST_CAL_ALL: clk_code = LANE_LOW;
            ST_CAL_HI:             clk_code = LANE_HIGH;
            ST_ACTIVE:             clk_code = LANE_ACT;
            default:               clk_code = LANE_OFF;
        endcase
    end

    for (genvar i = 0; i < DATA_LANES; i++) begin : g_data
        always_comb begin
            unique case (state)
                ST_CAL_ALL: data_code[2*i +: 2] = LANE_LOW;
                ST_ACTIVE:  data_code[2*i +: 2] = LANE_ACT;
                default:    data_code[2*i +: 2] = LANE_OFF;
            endcase
        end
    end
endmodule

// File: rtl/link_startup_seq.sv
module link_startup_seq
    import lss_pkg::*;
#(
    parameter int DATA_LANES   = 2,
    parameter int LOCK_PIX     = LOCK_PIX_DEF,
    parameter int CAL_LEN      = CAL_LEN_DEF,
    parameter int LOSS_TIMEOUT = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pd_n,
    input  logic                    pix_edge,
    input  logic                    pll_lock,
    output logic [1:0]              clk_lane,
    output logic [2*DATA_LANES-1:0] data_lane,
    output logic                    pd_out_n,
    output logic                    link_up
);
    logic       pix_lost;
    lss_state_t state;

    lss_clk_monitor #(.LOSS_TIMEOUT(LOSS_TIMEOUT)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .pix_edge (pix_edge),
        .pix_lost (pix_lost)
    );

    lss_seq_fsm #(.LOCK_PIX(LOCK_PIX), .CAL_LEN(CAL_LEN)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pd_n     (pd_n),
        .pix_edge (pix_edge),
        .pix_lost (pix_lost),
        .pll_lock (pll_lock),
        .state    (state)
    );

    lss_lane_encoder #(.DATA_LANES(DATA_LANES)) u_enc (
        .state     (state),
        .clk_code  (clk_lane),
        .data_code (data_lane)
    );

    assign pd_out_n = (state != ST_OFF);
    assign link_up  = (state == ST_ACTIVE);
endmodule

// File: rtl/link_startup_chk.sv
module link_startup_chk #(
    parameter int DATA_LANES   = 2,
    parameter int CAL_LEN      = 180,
    parameter int LOSS_TIMEOUT = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pd_n,
    input logic                    pix_edge,
    input logic [1:0]              clk_lane,
    input logic [2*DATA_LANES-1:0] data_lane,
    input logic                    pd_out_n,
    input logic                    link_up
);
    localparam logic [2*DATA_LANES-1:0] ALL_LOW = {DATA_LANES{2'b01}};
    localparam logic [2*DATA_LANES-1:0] ALL_ACT = {DATA_LANES{2'b11}};

    logic [1:0]  p_clk;
    logic [15:0] run;
    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_clk <= 2'd0;
            run   <= 16'd0;
            gap   <= 16'hFFFF;
        end else begin
            p_clk <= clk_lane;
            if (clk_lane != p_clk) run <= 16'd1;
            else if (run != 16'hFFFF) run <= run + 16'd1;
            if (pix_edge) gap <= 16'd0;
            else if (gap != 16'hFFFF) gap <= gap + 16'd1;
        end
    end

    AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (clk_lane == 2'd0 && data_lane == '0 && !pd_out_n)); // R10

    AST_LINK_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        link_up |-> pd_out_n); // R9

    AST_START_WITH_LOW: assert property (@(posedge clk) disable iff (rst)
        (p_clk == 2'd0 && clk_lane != 2'd0) |-> (clk_lane == 2'd1 && data_lane == '0)); // R3

    AST_LOW_STAGE_LEN: assert property (@(posedge clk) disable iff (rst)
        (p_clk == 2'd1 && clk_lane == 2'd2) |-> (run == 16'(CAL_LEN))); // R3

    AST_HIGH_STAGE_LEN: assert property (@(posedge clk) disable iff (rst)
        (p_clk == 2'd2 && clk_lane == 2'd1) |-> (run == 16'(CAL_LEN) && data_lane == ALL_LOW)); // R4

    AST_HIGH_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        (clk_lane == 2'd2 && p_clk != 2'd2) |-> (p_clk == 2'd1 && data_lane == '0)); // R4

    AST_ACTIVE_AFTER_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        (clk_lane == 2'd3 && p_clk != 2'd3) |-> (p_clk == 2'd1 && run == 16'(CAL_LEN))); // R5

    AST_ACTIVE_LANES: assert property (@(posedge clk) disable iff (rst)
        link_up |-> (clk_lane == 2'd3 && data_lane == ALL_ACT)); // R6

    AST_LOSS_POWERS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (gap > 16'(LOSS_TIMEOUT)) |-> (!pd_out_n && clk_lane == 2'd0)); // R7
endmodule

bind link_startup_seq link_startup_chk #(
    .DATA_LANES   (DATA_LANES),
    .CAL_LEN      (CAL_LEN),
    .LOSS_TIMEOUT (LOSS_TIMEOUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pd_n      (pd_n),
    .pix_edge  (pix_edge),
    .clk_lane  (clk_lane),
    .data_lane (data_lane),
    .pd_out_n  (pd_out_n),
    .link_up   (link_up)
);

// File: tb/tb_link_startup_seq.sv
module tb_link_startup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 24;
    localparam int CAL        = 180;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n = 1'b0;
    logic       pix_edge = 1'b0;
    logic       pll_lock = 1'b1;
    logic [1:0] clk_lane;
    logic [3:0] data_lane;
    logic       pd_out_n;
    logic       link_up;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    int  pdiv    = 0;
    int  edge_cnt = 0;
    bit  pix_run = 1'b0;

    link_startup_seq #(.LOSS_TIMEOUT(TIMEOUT)) dut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .pix_edge(pix_edge),
        .pll_lock(pll_lock), .clk_lane(clk_lane), .data_lane(data_lane),
        .pd_out_n(pd_out_n), .link_up(link_up)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog (all R) actual=%0d cycles expected<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        if (pix_run) begin
            pdiv = (pdiv == 5) ? 0 : pdiv + 1;
            pix_edge = (pdiv == 0);
        end else begin
            pix_edge = 1'b0;
        end
        if (pix_edge) edge_cnt++;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk_lane_on(output int waited);
        waited = 0;
        while (clk_lane == 2'd0 && waited < 40000) begin
            tick();
            waited++;
        end
    endtask

    task automatic measure_cal();
        int n;
        n = 0;
        while (clk_lane == 2'd1 && data_lane == 4'b0000 && n < 1000) begin tick(); n++; end
        chk(n == CAL, "R3 low stage length", n, CAL);
        chk(clk_lane == 2'd2, "R4 high stage follows", clk_lane, 2);
        n = 0;
        while (clk_lane == 2'd2 && data_lane == 4'b0000 && n < 1000) begin tick(); n++; end
        chk(n == CAL, "R4 high stage length", n, CAL);
        chk(clk_lane == 2'd1 && data_lane == 4'b0101, "R5 all-low entry", {clk_lane, data_lane}, 6'b010101);
        n = 0;
        while (clk_lane == 2'd1 && data_lane == 4'b0101 && n < 1000) begin tick(); n++; end
        chk(n == CAL, "R5 all-low length", n, CAL);
        chk(clk_lane == 2'd3 && data_lane == 4'b1111 && link_up, "R6 active entry",
            {link_up, clk_lane, data_lane}, 7'b1111111);
    endtask

    task automatic t_reset();
        chk(clk_lane == 2'd0 && data_lane == 4'd0, "R1 reset lanes off", {clk_lane, data_lane}, 0);
        chk(!pd_out_n && !link_up, "R1 reset pd_out_n/link_up", {pd_out_n, link_up}, 0);
    endtask

    task automatic t_hold_pd();
        pix_run = 1'b1;
        for (int i = 0; i < 200; i++) tick();
        chk(clk_lane == 2'd0 && data_lane == 4'd0 && !pd_out_n, "R1 pd_n low holds off",
            {pd_out_n, clk_lane, data_lane}, 0);
    endtask

    task automatic t_full_start();
        int w;
        edge_cnt = 0;
        pd_n = 1'b1;
        tick();
        tick();
        chk(pd_out_n == 1'b1, "R9 pd_out_n rises", pd_out_n, 1);
        wait_clk_lane_on(w);
        chk(edge_cnt >= 4096 && edge_cnt <= 4098, "R2 lock wait edges", edge_cnt, 4096);
        measure_cal();
        for (int i = 0; i < 500; i++) tick();
        chk(link_up && clk_lane == 2'd3, "R6 active persists", {link_up, clk_lane}, 7);
    endtask

    task automatic t_clock_loss();
        int w;
        pix_run = 1'b0;
        tick();
        tick();
        chk(link_up == 1'b1, "R7 no early drop", link_up, 1);
        for (int i = 0; i < TIMEOUT + 8; i++) tick();
        chk(!pd_out_n && clk_lane == 2'd0 && data_lane == 4'd0 && !link_up, "R7 clock loss off",
            {pd_out_n, link_up, clk_lane, data_lane}, 0);
        edge_cnt = 0;
        pix_run = 1'b1;
        wait_clk_lane_on(w);
        chk(edge_cnt >= 4096 && edge_cnt <= 4098, "R8 relock edges", edge_cnt, 4097);
        measure_cal();
    endtask

    task automatic t_pd_drop_active();
        pd_n = 1'b0;
        tick();
        chk(clk_lane == 2'd0 && data_lane == 4'd0 && !pd_out_n && !link_up, "R10 pd in active",
            {pd_out_n, link_up, clk_lane, data_lane}, 0);
    endtask

    task automatic t_late_lock();
        int w;
        pll_lock = 1'b0;
        pd_n = 1'b1;
        for (int i = 0; i < 4200 * 6; i++) tick();
        chk(clk_lane == 2'd0 && pd_out_n, "R2 waits for pll_lock", {pd_out_n, clk_lane}, 4);
        pll_lock = 1'b1;
        w = 0;
        while (clk_lane == 2'd0 && w < 20) begin tick(); w++; end
        chk(w <= 7 && clk_lane == 2'd1, "R2 start after lock", w, 7);
        measure_cal();
    endtask

    task automatic t_pd_mid_cal();
        int w;
        pd_n = 1'b0;
        tick();
        pd_n = 1'b1;
        wait_clk_lane_on(w);
        w = 0;
        while (clk_lane != 2'd2 && w < 400) begin tick(); w++; end
        for (int i = 0; i < 10; i++) tick();
        pd_n = 1'b0;
        tick();
        chk(clk_lane == 2'd0 && data_lane == 4'd0 && !pd_out_n, "R10 pd mid-calibration",
            {pd_out_n, clk_lane, data_lane}, 0);
        for (int i = 0; i < 50; i++) tick();
        chk(clk_lane == 2'd0 && !pd_out_n, "R1 stays off", {pd_out_n, clk_lane}, 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_hold_pd();
        t_full_start();
        t_clock_loss();
        t_pd_drop_active();
        t_late_lock();
        t_pd_mid_cal();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule